// File: doc/BRIEF.md
# ADC Power-State Command Sequencer

This block is the host-side master for a single-channel serial SAR converter that has no power-down pin and changes power state from how long its chip select is held low. A client hands the sequencer one command at a time over a valid/ready handshake: convert, sleep or wake. For each command the sequencer drives the active-low chip select and a serial clock, which it derives from the system clock through a programmable divider. It shifts the converter's serial output into a parallel sample, and it returns one response beat. Each response carries a flag that marks the sample as trustworthy or not.

The sequencer picks the frame length from the command. A sleep frame is cut short after four serial-clock falling edges. This falls inside the converter's window for a deliberate power-down, so a glitch-length frame cannot trigger it. Wake and convert frames run twenty falling edges, which takes the converter past its power-up threshold. The block keeps its own record of whether the converter is awake. If a convert command arrives while that record says asleep, the sequencer first inserts a hidden wake frame and then runs the real conversion. Samples taken during any wake frame are flagged untrustworthy.

Top module: `adc_pwr_seq`

## Requirements
- R1: After synchronous reset, chip select and serial clock are high, `cmd_ready` is 1, `rsp_valid` is 0 and `pwr_up` is 1 (the converter is assumed awake).
- R2: The serial clock idles high whenever chip select is high. While a frame runs, each half period lasts `cfg_half`+1 system clocks, and the first half period after chip select falls is high.
- R3: A convert command (`cmd_op` = 2'b00) produces a frame of 20 falling edges. The input is sampled on each rising edge. The response has `rsp_good` = 1 and `rsp_data` equal to the last 16 sampled bits, first-sampled bit most significant.
- R4: A sleep command (`cmd_op` = 2'b01) raises chip select on the clock of the 4th rising edge, after exactly 4 falling edges and never before the 2nd. Its response has `rsp_good` = 0 and `rsp_data` = 0, and `pwr_up` becomes 0 at that clock.
- R5: A wake command (`cmd_op` = 2'b10) runs a 20-falling-edge frame whether or not the converter is awake. Its response carries the captured bits with `rsp_good` = 0, and `pwr_up` becomes 1. A convert issued after it needs no extra frame.
- R6: A convert issued while `pwr_up` is 0 first runs a 20-edge wake frame that gives no response. A chip-select gap follows, then the 20-edge conversion frame. The command gives exactly one response, with `rsp_good` = 1.
- R7: Between any two frames, including between an automatic wake frame and its conversion, chip select stays high for at least `cfg_gap`+1 system clocks.
- R8: `cmd_ready` is 0 from the accepting clock until the gap after the command's last frame has expired. Each command yields exactly one single-clock `rsp_valid` pulse, on the clock where chip select rises at the end of its last frame.
- R9: Command code 2'b11 behaves exactly like a convert, including the automatic wake when asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half | input | DIV_W | Serial clock half period minus one, in system clocks |
| cfg_gap | input | GAP_W | Minimum chip-select high time minus one, in system clocks |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_op | input | 2 | 00 convert, 01 sleep, 10 wake, 11 convert |
| rsp_valid | output | 1 | One-clock response strobe |
| rsp_good | output | 1 | Response sample is a trustworthy conversion |
| rsp_data | output | SMP_W | Captured sample |
| pwr_up | output | 1 | Tracked converter power state, 1 = awake |
| adc_cs_n | output | 1 | Active-low chip select to the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_sdata | input | 1 | Serial data from the converter |

## Verification
The bench attacks the edge counts that decide the converter's power state. If a sleep frame ran one falling edge too many or too few, the per-clock waveform comparison and the fall count from the bench's converter model would both disagree. A convert issued while asleep must cost 40 falling edges and a single trustworthy response. A design that forgot the hidden wake frame would show 20 edges, and one that let the hidden frame answer would show two responses. The divider is run at its shortest half period and with zero gap, so that off-by-one errors in the half-period count, or a gap that collapses to nothing, would shift every later chip-select and clock transition. Code 2'b11 and a wake issued while already awake check that the command decoding does not drop to a wrong default.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Protocol constants of the converter's framing
    localparam int FRAME_EDGES = 20;
    localparam int PD_EDGES    = 4;
    localparam int EDGE_W      = $clog2(FRAME_EDGES + 1);

    typedef enum logic [1:0] {
        OP_CONV     = 2'b00,
        OP_SLEEP    = 2'b01,
        OP_WAKE     = 2'b10,
        OP_CONV_ALT = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_GAP
    } st_e;

    typedef enum logic [1:0] {
        FK_CONV,
        FK_SLEEP,
        FK_WAKE,
        FK_PREWAKE
    } fkind_e;

    // First frame to run for an accepted command
    function automatic fkind_e first_kind(op_e op, logic awake);
        fkind_e k;
        case (op)
            OP_SLEEP: k = FK_SLEEP;
            OP_WAKE:  k = FK_WAKE;
            default:  k = awake ? FK_CONV : FK_PREWAKE;
        endcase
        return k;
    endfunction

    // Number of serial clock cycles in a frame of the given kind
    function automatic logic [EDGE_W-1:0] kind_edges(fkind_e k);
        return (k == FK_SLEEP) ? EDGE_W'(PD_EDGES) : EDGE_W'(FRAME_EDGES);
    endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             sclk,
    output logic             fall_stb,
    output logic             rise_stb
);

    logic [DIV_W-1:0] cnt_q;
    logic             sclk_q;
    logic             tick;

    assign tick     = run && (cnt_q == half);
    assign fall_stb = tick && sclk_q;
    assign rise_stb = tick && !sclk_q;
    assign sclk     = sclk_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (tick) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + DIV_W'(1);
        end
    end

    // R2: a clock that is not running rests high on the next cycle
    p_rest_high_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> sclk_q);

endmodule

// File: rtl/adc_shift_in.sv
module adc_shift_in #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (en) begin
            q <= {q[W-2:0], din};
        end
    end

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
    import adc_seq_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int GAP_W = 8,
    parameter int SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] cfg_half,
    input  logic [GAP_W-1:0] cfg_gap,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_op,
    output logic             rsp_valid,
    output logic             rsp_good,
    output logic [SMP_W-1:0] rsp_data,
    output logic             pwr_up,
    output logic             adc_cs_n,
    output logic             adc_sclk,
    input  logic             adc_sdata
);

    localparam int HI_W = GAP_W + 1;

    st_e              st;
    fkind_e           kind;
    op_e              op_in;
    logic [EDGE_W-1:0] rise_cnt;
    logic [EDGE_W-1:0] fall_cnt;
    logic [EDGE_W-1:0] last_idx;
    logic [GAP_W-1:0] gap_cnt;
    logic             pwr_q;
    logic             pend_q;
    logic             in_frame;
    logic             fall_stb;
    logic             rise_stb;
    logic             last_rise;
    logic [SMP_W-1:0] sh_q;
    logic [SMP_W-1:0] word_nx;

    assign op_in     = op_e'(cmd_op);
    assign in_frame  = (st == ST_FRAME);
    assign last_idx  = kind_edges(kind) - EDGE_W'(1);
    assign last_rise = in_frame && rise_stb && (rise_cnt == last_idx);
    assign word_nx   = {sh_q[SMP_W-2:0], adc_sdata};

    assign adc_cs_n  = !in_frame;
    assign cmd_ready = (st == ST_IDLE);
    assign pwr_up    = pwr_q;

    adc_sclk_gen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .run      (in_frame),
        .half     (cfg_half),
        .sclk     (adc_sclk),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb)
    );

    adc_shift_in #(.W(SMP_W)) u_shift (
        .clk (clk),
        .rst (rst),
        .clr (!in_frame),
        .en  (in_frame && rise_stb),
        .din (adc_sdata),
        .q   (sh_q)
    );

    // Falling edges seen in the current frame
    always_ff @(posedge clk) begin
        if (rst || !in_frame) begin
            fall_cnt <= '0;
        end else if (fall_stb) begin
            fall_cnt <= fall_cnt + EDGE_W'(1);
        end
    end

    // Frame sequencing, power tracking and response
    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            kind      <= FK_CONV;
            rise_cnt  <= '0;
            gap_cnt   <= '0;
            pwr_q     <= 1'b1;
            pend_q    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_good  <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        st       <= ST_FRAME;
                        kind     <= first_kind(op_in, pwr_q);
                        rise_cnt <= '0;
                    end
                end
                ST_FRAME: begin
                    if (rise_stb) begin
                        rise_cnt <= rise_cnt + EDGE_W'(1);
                    end
                    if (last_rise) begin
                        st      <= ST_GAP;
                        gap_cnt <= cfg_gap;
                        pwr_q   <= (kind != FK_SLEEP);
                        case (kind)
                            FK_PREWAKE: pend_q <= 1'b1;
                            FK_SLEEP: begin
                                rsp_valid <= 1'b1;
                                rsp_good  <= 1'b0;
                                rsp_data  <= '0;
                            end
                            FK_WAKE: begin
                                rsp_valid <= 1'b1;
                                rsp_good  <= 1'b0;
                                rsp_data  <= word_nx;
                            end
                            default: begin
                                rsp_valid <= 1'b1;
                                rsp_good  <= 1'b1;
                                rsp_data  <= word_nx;
                            end
                        endcase
                    end
                end
                default: begin
                    if (gap_cnt == '0) begin
                        if (pend_q) begin
                            st       <= ST_FRAME;
                            kind     <= FK_CONV;
                            rise_cnt <= '0;
                            pend_q   <= 1'b0;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else begin
                        gap_cnt <= gap_cnt - GAP_W'(1);
                    end
                end
            endcase
        end
    end

    // Checker state: clocks chip select has been high, saturating
    logic [HI_W-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '1;
        end else if (!adc_cs_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt != '1) begin
            hi_cnt <= hi_cnt + HI_W'(1);
        end
    end

    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> adc_sclk);

    p_sleep_edges_r4: assert property (@(posedge clk) disable iff (rst)
        (last_rise && kind == FK_SLEEP) |-> (fall_cnt == EDGE_W'(PD_EDGES)));

    p_full_edges_r5: assert property (@(posedge clk) disable iff (rst)
        (last_rise && kind != FK_SLEEP) |-> (fall_cnt == EDGE_W'(FRAME_EDGES)));

    p_prewake_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (last_rise && kind == FK_PREWAKE) |=> !rsp_valid);

    p_good_awake_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_good) |-> pwr_up);

    p_cs_gap_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cs_n) |-> (hi_cnt >= ({1'b0, cfg_gap} + HI_W'(1))));

    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_rsp_busy_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (!cmd_ready && adc_cs_n));

endmodule

// File: tb/tb_adc_pwr_seq.sv
`timescale 1ns/1ps
module tb_adc_pwr_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_half = 8'd1;
    logic [7:0]  cfg_gap = 8'd2;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic        cmd_ready;
    logic        rsp_valid;
    logic        rsp_good;
    logic [15:0] rsp_data;
    logic        pwr_up;
    logic        adc_cs_n;
    logic        adc_sclk;
    logic        adc_sdata = 1'b0;

    always #4 clk = ~clk;

    adc_pwr_seq dut (
        .clk(clk), .rst(rst), .cfg_half(cfg_half), .cfg_gap(cfg_gap),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .rsp_valid(rsp_valid), .rsp_good(rsp_good), .rsp_data(rsp_data),
        .pwr_up(pwr_up), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
        .adc_sdata(adc_sdata)
    );

    // Converter model: four leading zeros, then the sample, one bit per falling edge
    logic [19:0] adc_frame = 20'h0;
    int fidx = 0;
    int falls_total = 0;
    always @(negedge adc_sclk or negedge adc_cs_n) begin
        if (adc_sclk) begin
            fidx = 0;
            adc_sdata <= 1'b0;
        end else if (!adc_cs_n) begin
            fidx = fidx + 1;
            falls_total = falls_total + 1;
            if (fidx <= 20) adc_sdata <= adc_frame[20 - fidx];
        end
    end

    // Reference model: expected pin values per system clock interval
    typedef struct packed {
        logic        cs;
        logic        sc;
        logic        rdy;
        logic        rv;
        logic        good;
        logic [15:0] data;
        logic        pw;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    bit   m_pwr = 1'b1;

    task automatic push_frame(int n, bit rsp, bit good, logic [15:0] d,
                              bit pw_pre, bit pw_post, int h, int g);
        exp_t e;
        for (int c = 0; c < 2 * n * h; c++) begin
            e = '{cs: 1'b0, sc: ((c / h) % 2 == 0), rdy: 1'b0, rv: 1'b0,
                  good: 1'b0, data: 16'h0, pw: pw_pre};
            q.push_back(e);
        end
        for (int c = 0; c <= g; c++) begin
            e = '{cs: 1'b1, sc: 1'b1, rdy: 1'b0, rv: (c == 0) && rsp,
                  good: good, data: d, pw: pw_post};
            q.push_back(e);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_pwr = 1'b1;
            cur = '{cs: 1'b1, sc: 1'b1, rdy: 1'b1, rv: 1'b0, good: 1'b0, data: 16'h0, pw: 1'b1};
        end else begin
            if (q.size() == 0 && cmd_valid) begin
                int h;
                int g;
                h = int'(cfg_half) + 1;
                g = int'(cfg_gap);
                case (cmd_op)
                    2'b01: begin
                        push_frame(4, 1, 0, 16'h0, m_pwr, 0, h, g);
                        m_pwr = 1'b0;
                    end
                    2'b10: begin
                        push_frame(20, 1, 0, adc_frame[15:0], m_pwr, 1, h, g);
                        m_pwr = 1'b1;
                    end
                    default: begin
                        if (!m_pwr) push_frame(20, 0, 0, 16'h0, 0, 1, h, g);
                        push_frame(20, 1, 1, adc_frame[15:0], 1, 1, h, g);
                        m_pwr = 1'b1;
                    end
                endcase
            end
            if (q.size() > 0) cur = q.pop_front();
            else cur = '{cs: 1'b1, sc: 1'b1, rdy: 1'b1, rv: 1'b0, good: 1'b0, data: 16'h0, pw: m_pwr};
        end
    end

    // Counters written by the directed sequence
    int chk_n = 0;
    int err_n = 0;
    // Counters written by the per-clock comparator
    int clk_n = 0;
    int clk_e = 0;
    int cyc = 0;
    int rsp_cnt = 0;
    bit last_good = 1'b0;
    logic [15:0] last_data = 16'h0;
    bit done = 1'b0;

    task automatic clk_cmp(bit ok, string tag, int act, int exp);
        clk_n = clk_n + 1;
        if (!ok) begin
            clk_e = clk_e + 1;
            $display("FAIL %s cycle %0d actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst) begin
            clk_cmp(adc_cs_n == cur.cs, "R7 chip select", adc_cs_n, cur.cs);
            clk_cmp(adc_sclk == cur.sc, "R2 serial clock", adc_sclk, cur.sc);
            clk_cmp(cmd_ready == cur.rdy, "R8 cmd_ready", cmd_ready, cur.rdy);
            clk_cmp(rsp_valid == cur.rv, "R8 rsp_valid", rsp_valid, cur.rv);
            clk_cmp(pwr_up == cur.pw, "R4 pwr_up", pwr_up, cur.pw);
            if (cur.rv && rsp_valid) begin
                clk_cmp(rsp_good == cur.good, "R3 rsp_good", rsp_good, cur.good);
                clk_cmp(rsp_data == cur.data, "R3 rsp_data", rsp_data, cur.data);
            end
            if (rsp_valid) begin
                rsp_cnt = rsp_cnt + 1;
                last_good = rsp_good;
                last_data = rsp_data;
            end
        end
        if (cyc > 100000 && !done) begin
            clk_e = clk_e + 1;
            $display("FAIL R8 watchdog expired actual %0d expected below 100000", cyc);
            $display("CHECKS %0d ERRORS %0d", chk_n + clk_n, err_n + clk_e);
            $finish;
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        chk_n = chk_n + 1;
        if (!ok) begin
            err_n = err_n + 1;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(int h, int g);
        @(negedge clk);
        cfg_half = 8'(h);
        cfg_gap = 8'(g);
        repeat (12) @(negedge clk);
    endtask

    task automatic run_cmd(logic [1:0] op, logic [15:0] word, int exp_falls,
                           bit exp_good, logic [15:0] exp_data, string tag);
        int f0;
        int r0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        adc_frame = {4'h0, word};
        f0 = falls_total;
        r0 = rsp_cnt;
        cmd_op = op;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
        check(falls_total - f0 == exp_falls, {tag, " falling edge count"}, falls_total - f0, exp_falls);
        check(rsp_cnt - r0 == 1, {tag, " R8 one response"}, rsp_cnt - r0, 1);
        check(last_good == exp_good, {tag, " response flag"}, last_good, exp_good);
        check(last_data == exp_data, {tag, " response data"}, last_data, exp_data);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(adc_cs_n == 1'b1, "R1 cs_n in reset", adc_cs_n, 1);
        rst = 1'b0;
        @(negedge clk);
        check(adc_cs_n == 1'b1 && adc_sclk == 1'b1, "R1 pins idle", {adc_cs_n, adc_sclk}, 3);
        check(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
        check(rsp_valid == 1'b0, "R1 no response", rsp_valid, 0);
        check(pwr_up == 1'b1, "R1 awake", pwr_up, 1);

        set_cfg(1, 2);
        run_cmd(2'b00, 16'hA5C3, 20, 1, 16'hA5C3, "R3 convert");
        run_cmd(2'b11, 16'h1234, 20, 1, 16'h1234, "R9 alternate convert");
        run_cmd(2'b01, 16'hFFFF, 4, 0, 16'h0000, "R4 sleep");
        check(pwr_up == 1'b0, "R4 asleep after sleep", pwr_up, 0);
        run_cmd(2'b00, 16'hBEEF, 40, 1, 16'hBEEF, "R6 convert while asleep");
        check(pwr_up == 1'b1, "R6 awake after convert", pwr_up, 1);
        run_cmd(2'b01, 16'h0000, 4, 0, 16'h0000, "R4 sleep again");
        run_cmd(2'b10, 16'h0F0F, 20, 0, 16'h0F0F, "R5 wake");
        check(pwr_up == 1'b1, "R5 awake after wake", pwr_up, 1);
        run_cmd(2'b00, 16'h8001, 20, 1, 16'h8001, "R5 convert after wake");

        set_cfg(0, 0);
        run_cmd(2'b00, 16'hFFFF, 20, 1, 16'hFFFF, "R2 fastest convert");
        run_cmd(2'b01, 16'h5555, 4, 0, 16'h0000, "R4 fast sleep");
        run_cmd(2'b00, 16'h0001, 40, 1, 16'h0001, "R7 zero gap wake then convert");

        set_cfg(3, 7);
        run_cmd(2'b01, 16'h1111, 4, 0, 16'h0000, "R4 slow sleep");
        run_cmd(2'b11, 16'h7E81, 40, 1, 16'h7E81, "R9 alternate convert while asleep");
        run_cmd(2'b10, 16'hC00C, 20, 0, 16'hC00C, "R5 wake while awake");
        check(pwr_up == 1'b1, "R5 still awake", pwr_up, 1);

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", chk_n + clk_n, err_n + clk_e);
        $finish;
    end

endmodule